// File: doc/BRIEF.md
# Power-of-Two Interval Trigger Timer

This block is a prescaled timer that issues internal trigger pulses to the queue sequencer of an analog converter. Each trigger starts a queue at its first entry or resumes a queue that paused. The interval is a power of two of the converter clock. The converter clock reaches the block as a one-cycle `tick` enable, and a small select field picks the exponent.

Two queues share the timer. Before its first trigger, a queue needs two things: interval-timer mode and its single-scan enable bit. A rising edge on any per-queue enable bit starts the timer. Once started, the timer fires every interval. If the sequencer is still busy when a trigger fires, the block raises an overrun flag with that trigger. The timer stops and clears on end-of-queue, but only once every queue that still uses it has reached end-of-queue. After that it stays idle until an enable bit rises again.

Top module: `interval_trigger_timer`

## Requirements
- R1: After reset, `trigger` and `overrun` are low, and no trigger is issued until at least one bit of `qEnable` has gone from 0 to 1.
- R2: When the timer is idle, a 0-to-1 change on any `qEnable` bit starts it with the count at zero. The first trigger appears in the cycle after the P-th counted tick. P = 2^(MIN_EXP + min(code, MAX_EXP - MIN_EXP)), where code is the unsigned value of `periodSel`. With the defaults, code is 4 bits wide and codes 0 to 10 give 2^7 to 2^17.
- R3: A `periodSel` code above MAX_EXP - MIN_EXP gives the longest interval, 2^MAX_EXP.
- R4: Only clock edges that sample `tick` high advance the count. Cycles with `tick` low do not advance it.
- R5: `trigger` is high for exactly one cycle. The count returns to zero on the edge that fires it, so successive triggers are exactly P counted ticks apart.
- R6: `overrun` is high in the same cycle as a trigger when `qBusy` was high on the firing edge. At all other times it is low.
- R7: An end-of-queue pulse on `qEoq` stops the timer and clears its count when no other queue is active. No trigger follows it. After a restart, the next trigger comes a full P ticks later.
- R8: An end-of-queue pulse from one queue leaves the count and trigger schedule unchanged while another queue still shows `qActive` high.
- R9: The timer stops once every active queue has reached end-of-queue. This includes the case where the last one ends later, and the case where several end on the same edge.
- R10: After a stop, holding an enable bit high does not restart the timer. Only a new 0-to-1 change restarts it.
- R11: A 0-to-1 change on an enable bit while the timer is already running does not change the trigger schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Converter-clock enable; one counted tick per high cycle |
| periodSel | input | SEL_W | Interval exponent code |
| qEnable | input | NUM_Q | Per-queue single-scan enable in interval-timer mode |
| qActive | input | NUM_Q | Per-queue "scan in progress" indication |
| qEoq | input | NUM_Q | Per-queue end-of-queue pulse |
| qBusy | input | 1 | Sequencer is executing and cannot accept a trigger |
| trigger | output | 1 | One-cycle trigger pulse |
| overrun | output | 1 | Trigger arrived while the sequencer was busy |

## Verification
The start edge, where the enable rise is sampled, does not count. After it, each trigger is due in the cycle that follows the P-th edge sampling `tick` high. The `overrun` flag and a stop both act on the same edge as the stimulus that causes them. The bench drives and samples one time unit after every rising edge. Before each edge it records whether `tick` is about to be sampled high, and it compares the resulting tick count with P when the trigger is observed. Stop rules are checked over windows longer than the largest interval.

// File: rtl/itt_pkg.sv
package itt_pkg;
  // Strobes from the control FSM to the counting datapath.
  typedef struct packed {
    logic cntAdv;  // advance the counter on this edge
    logic cntClr;  // force the counter to zero on this edge
  } ittStrobe_t;
endpackage

// File: rtl/itt_ctrl.sv
module itt_ctrl #(
  parameter int NUM_Q = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic [NUM_Q-1:0]     qEnable,
  input  logic [NUM_Q-1:0]     qActive,
  input  logic [NUM_Q-1:0]     qEoq,
  output itt_pkg::ittStrobe_t  strobe
);
  logic             running;
  logic [NUM_Q-1:0] prevEn;
  logic [NUM_Q-1:0] stillUsing;
  logic             enRise;
  logic             startEv;
  logic             stopEv;

  // A queue still holds the timer if it is active and not ending on this edge.
  for (genvar q = 0; q < NUM_Q; q++) begin : g_use
    assign stillUsing[q] = qActive[q] & ~qEoq[q];
  end

  assign enRise  = |(qEnable & ~prevEn);
  assign startEv = enRise && !running;
  assign stopEv  = running && (|qEoq) && (stillUsing == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      prevEn  <= '0;
    end else begin
      prevEn <= qEnable;
      if (startEv)     running <= 1'b1;
      else if (stopEv) running <= 1'b0;
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.cntClr = startEv || stopEv;
    strobe.cntAdv = running && tick && !stopEv;
  end
endmodule

// File: rtl/itt_datapath.sv
module itt_datapath #(
  parameter int SEL_W   = 4,
  parameter int MIN_EXP = 7,
  parameter int MAX_EXP = 17
) (
  input  logic                clk,
  input  logic                rstN,
  input  itt_pkg::ittStrobe_t strobe,
  input  logic [SEL_W-1:0]    periodSel,
  input  logic                qBusy,
  output logic                trigger,
  output logic                overrun
);
  localparam int CNT_W = MAX_EXP;
  localparam int MAX_CODE = MAX_EXP - MIN_EXP;
  localparam logic [SEL_W-1:0] MAX_CODE_S = SEL_W'(MAX_CODE);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastVal;
  logic [SEL_W-1:0] codeClamped;
  logic             atLast;
  logic             fire;

  always_comb begin
    codeClamped = (periodSel > MAX_CODE_S) ? MAX_CODE_S : periodSel;
    lastVal     = ALL_ONES >> (MAX_CODE - int'(codeClamped));
  end

  // >= keeps a shortened interval from running past its terminal value.
  assign atLast = (count >= lastVal);
  assign fire   = strobe.cntAdv && atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      trigger <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (strobe.cntClr)      count <= '0;
      else if (fire)          count <= '0;
      else if (strobe.cntAdv) count <= count + 1'b1;
      trigger <= fire;
      overrun <= fire && qBusy;
    end
  end
endmodule

// File: rtl/interval_trigger_timer.sv
module interval_trigger_timer #(
  parameter int NUM_Q   = 2,
  parameter int SEL_W   = 4,
  parameter int MIN_EXP = 7,
  parameter int MAX_EXP = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [SEL_W-1:0] periodSel,
  input  logic [NUM_Q-1:0] qEnable,
  input  logic [NUM_Q-1:0] qActive,
  input  logic [NUM_Q-1:0] qEoq,
  input  logic             qBusy,
  output logic             trigger,
  output logic             overrun
);
  itt_pkg::ittStrobe_t strobe;

  itt_ctrl #(.NUM_Q(NUM_Q)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .qEnable(qEnable), .qActive(qActive), .qEoq(qEoq),
    .strobe(strobe)
  );

  itt_datapath #(.SEL_W(SEL_W), .MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .periodSel(periodSel), .qBusy(qBusy),
    .trigger(trigger), .overrun(overrun)
  );
endmodule

// File: rtl/itt_checker.sv
module itt_checker #(
  parameter int NUM_Q = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic [NUM_Q-1:0] qEnable,
  input logic [NUM_Q-1:0] qActive,
  input logic [NUM_Q-1:0] qEoq,
  input logic             qBusy,
  input logic             trigger,
  input logic             overrun
);
  logic [NUM_Q-1:0] enSeen;
  logic             seenRise;
  logic             allDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSeen   <= '0;
      seenRise <= 1'b0;
    end else begin
      enSeen <= qEnable;
      if (|(qEnable & ~enSeen)) seenRise <= 1'b1;
    end
  end

  assign allDone = (|qEoq) && ((qActive & ~qEoq) == '0);

  AST_NO_EARLY_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    !seenRise |-> !trigger); // R1
  AST_TRIGGER_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> $past(tick)); // R4
  AST_TRIGGER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    trigger |=> !trigger); // R5
  AST_OVERRUN_WITH_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> trigger); // R6
  AST_OVERRUN_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> (overrun == $past(qBusy))); // R6
  AST_STOP_SUPPRESSES_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    allDone |=> !trigger); // R9
endmodule

bind interval_trigger_timer itt_checker #(.NUM_Q(NUM_Q)) chk (
  .clk(clk), .rstN(rstN), .tick(tick),
  .qEnable(qEnable), .qActive(qActive), .qEoq(qEoq),
  .qBusy(qBusy), .trigger(trigger), .overrun(overrun)
);

// File: tb/interval_trigger_timer_test.sv
`timescale 1ns/1ps
module interval_trigger_timer_test;
  localparam int NQ = 2;
  localparam int SW = 3;
  localparam int MINE = 2;
  localparam int MAXE = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic [SW-1:0] periodSel = '0;
  logic [NQ-1:0] qEnable = '0;
  logic [NQ-1:0] qActive = '0;
  logic [NQ-1:0] qEoq = '0;
  logic qBusy = 1'b0;
  logic trigger;
  logic overrun;

  int checks = 0;
  int errors = 0;
  int tickDiv = 1;
  int phase = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  interval_trigger_timer #(.NUM_Q(NQ), .SEL_W(SW), .MIN_EXP(MINE), .MAX_EXP(MAXE)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .periodSel(periodSel),
    .qEnable(qEnable), .qActive(qActive), .qEoq(qEoq), .qBusy(qBusy),
    .trigger(trigger), .overrun(overrun)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int period(int code);
    int c;
    c = (code > MAXE - MINE) ? MAXE - MINE : code;
    return 1 << (MINE + c);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    phase++;
    tick = ((phase % tickDiv) == 0);
  endtask

  // Counts ticks that the next edges sample, up to and including the firing edge.
  task automatic waitTrig(output int ticks);
    ticks = 0;
    for (int i = 0; i < 2000; i++) begin
      int pend;
      pend = tick;
      step();
      ticks += pend;
      if (trigger) return;
    end
    ticks = -1;
  endtask

  task automatic quietFor(int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (trigger) seen++;
    end
  endtask

  task automatic stopAll();
    qActive = '1; qEoq = '1;
    step();
    qEoq = '0; qActive = '0; qEnable = '0; qBusy = 1'b0;
    step();
  endtask

  task automatic startQ(int q);
    qEnable[q] = 1'b0;
    step();
    qEnable[q] = 1'b1;
    step();
  endtask

  initial begin
    int t;
    int seen;
    int pre;
    #1;
    check(trigger == 1'b0 && overrun == 1'b0, "R1 reset outputs", {trigger, overrun}, 0);
    step(); step();
    rstN = 1'b1;
    quietFor(200, seen);
    check(seen == 0, "R1 no trigger without enable", seen, 0);

    // Sweep every code with a tick every cycle and every third cycle.
    foreach (tickDivs[k]) begin
      tickDiv = tickDivs[k];
      for (int code = 0; code < (1 << SW); code++) begin
        stopAll();
        periodSel = SW'(code);
        startQ(0);
        waitTrig(t);
        if (code > MAXE - MINE)
          check(t == period(code), "R3 clamped first interval", t, period(code));
        else if (tickDiv == 1)
          check(t == period(code), "R2 first interval", t, period(code));
        else
          check(t == period(code), "R4 gated first interval", t, period(code));
        check(overrun == 1'b0, "R6 no overrun when idle", overrun, 0);
        waitTrig(t);
        check(t == period(code), "R5 successive interval", t, period(code));
      end
    end
    tickDiv = 1;

    // R6: overrun when busy at the firing edge
    stopAll();
    periodSel = 3'd0;
    startQ(0);
    qBusy = 1'b1;
    waitTrig(t);
    check(overrun == 1'b1, "R6 overrun while busy", overrun, 1);
    qBusy = 1'b0;
    waitTrig(t);
    check(overrun == 1'b0, "R6 no overrun after busy drops", overrun, 0);

    // R7 and R10: single queue end-of-queue stops and clears
    stopAll();
    periodSel = 3'd2;
    qActive = 2'b01;
    startQ(0);
    for (int i = 0; i < 6; i++) step();
    qEoq = 2'b01;
    step();
    qEoq = '0; qActive = '0;
    quietFor(80, seen);
    check(seen == 0, "R7 no trigger after end-of-queue", seen, 0);
    check(seen == 0, "R10 held enable does not restart", seen, 0);
    qActive = 2'b01;
    startQ(0);
    waitTrig(t);
    check(t == 16, "R7 full interval after restart", t, 16);

    // R11: enable rise on the other queue while running
    stopAll();
    periodSel = 3'd2;
    qActive = 2'b01;
    startQ(0);
    for (int i = 0; i < 5; i++) step();
    qEnable[1] = 1'b1;
    step();
    pre = 6;
    waitTrig(t);
    check(pre + t == 16, "R11 schedule kept on enable rise", pre + t, 16);

    // R8 and R9: shared reset between two queues
    stopAll();
    periodSel = 3'd2;
    qActive = 2'b11;
    startQ(0);
    for (int i = 0; i < 4; i++) step();
    qEoq = 2'b01;
    step();
    qEoq = '0; qActive = 2'b10;
    pre = 5;
    waitTrig(t);
    check(pre + t == 16, "R8 other queue active keeps count", pre + t, 16);
    step(); step();
    qEoq = 2'b10;
    step();
    qEoq = '0; qActive = '0;
    quietFor(80, seen);
    check(seen == 0, "R9 stop after last queue ends", seen, 0);

    qActive = 2'b11;
    startQ(0);
    for (int i = 0; i < 3; i++) step();
    qEoq = 2'b11;
    step();
    qEoq = '0; qActive = '0;
    quietFor(80, seen);
    check(seen == 0, "R9 stop on simultaneous end-of-queue", seen, 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  int tickDivs[2] = '{1, 3};
endmodule